// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (SMBus, with an I2C fallback). It holds nine 8-bit configuration registers and gives a host read and write access to them. Each register's contents also appear on a parallel output bus, so that neighbouring logic can use the settings directly. The block answers one fixed device address. By default it uses SMBus block transfers: a write carries its own length, and a read first returns a length byte taken from a host-writable register. Setting the top bit of the command byte selects a simpler byte mode, in which no length byte is used in either direction.

The bus lines are brought into the system clock domain through a synchronizer chain. Bus conditions are then decoded from the synchronized levels. The slave pulls SDA low through an output-enable signal and never drives it high. Some registers have special behaviour. Two bits of one register are loaded from strap pins when reset is released. One register returns a fixed identification code. One register is reserved. Reads of unused indices return zero.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read), which is the 7-bit address 0x69 plus the direction bit. For any other address it does not acknowledge, and it leaves SDA released until the next START.
- R2: Block write: address 0xD2, a command byte with bit 7 clear whose bits 6:0 give the start index N, a count byte X, then X data bytes. These bytes are stored at N, N+1 and onward. Every one of these bytes is acknowledged.
- R3: In a block write, a data byte that arrives after X bytes have already been stored is not acknowledged and is not stored.
- R4: Block read: 0xD2, command N, repeated START, 0xD3. The slave first sends the contents of register 8. It then sends the registers from index N upward, and keeps sending until the host does not acknowledge a byte.
- R5: Register 8 can be read and written, and resets to 0x05.
- R6: Byte mode is selected by setting bit 7 of the command byte. No count byte is used. Written bytes go to the index in bits 6:0 and then to the following indices. A read returns data from that index with no count byte in front.
- R7: Reset values are: register 0 = 0x07, registers 1 and 2 = 0xFF, registers 3 and 6 = 0x00, register 8 = 0x05.
- R8: Register 4 bits 3:2 take the value of the strap inputs when reset is released, and the host can overwrite them afterwards. Register 4 bits 5:4 always read 0, and writes to them are ignored.
- R9: Register 7 always reads 0x01 (identification). Register 5 always reads 0x00. Writes to either one are acknowledged but have no effect.
- R10: An index above 8 reads as 0x00. A write to such an index is acknowledged and changes no register.
- R11: A START or STOP in the middle of a transfer ends it. Bytes already stored stay stored, and the slave goes back to address matching.
- R12: The slave changes SDA only while SCL is low, except that a STOP releases it. SDA is released after a STOP.
- R13: Output bits [8k+7:8k] show register k. They change only when a data byte is written, or when the strap bits are loaded just after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_fs_i | input | 2 | Strap inputs loaded into register 4 bits 3:2 |
| sda_oe_o | output | 1 | When 1, pulls SDA low |
| cfg_o | output | 72 | Register k on bits [8k+7:8k] |

## Verification
Each reaction of the slave follows an SCL or SDA edge after the synchronizer chain, the edge-detect flop and one state register. That is about four system clocks: an ACK level or transmitted bit appears on SDA that long after SCL falls, and a written register appears on the parallel bus that long after the eighth falling edge of its data byte. The bench's bus driver changes SDA a quarter bit period after each SCL fall and samples SDA halfway through SCL high, both many clocks away from these points. Register contents are compared only after the STOP that ends a transaction. Read data passes through a scoreboard queue, so each returned byte is compared in order against the value the requirements predict.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

   localparam int BYTE_W  = 8;
   localparam int IDX_W   = 7;   // command byte bits 6:0 carry the index
   localparam int IDX_CNT = 8;   // read-length register
   localparam int IDX_ID  = 7;   // fixed identification register
   localparam int IDX_RSV = 5;   // reserved register
   localparam int IDX_FS  = 4;   // register holding the strap bits
   localparam int FS_LSB  = 2;   // strap bit position inside IDX_FS

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_HACK
   } smb_state_e;

   typedef enum logic [2:0] {
      PH_ADDR,
      PH_CMD,
      PH_CNT,
      PH_WDATA,
      PH_TCNT,
      PH_TDATA
   } smb_phase_e;

   function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
      case (idx)
         0:       return 8'h07;
         1, 2:    return 8'hFF;
         IDX_CNT: return 8'h05;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
      case (idx)
         IDX_FS:          return 8'hCF;
         IDX_RSV, IDX_ID: return 8'h00;
         default:         return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_p;
   logic [STAGES-1:0] sda_p;
   logic              scl_q;
   logic              sda_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_p[s] <= 1'b1;
                  sda_p[s] <= 1'b1;
               end else begin
                  scl_p[s] <= scl_i;
                  sda_p[s] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_p[s] <= 1'b1;
                  sda_p[s] <= 1'b1;
               end else begin
                  scl_p[s] <= scl_p[s-1];
                  sda_p[s] <= sda_p[s-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_p[STAGES-1];
   assign sda_s = sda_p[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = !scl_q && scl_s;
   assign scl_fall  = scl_q && !scl_s;
   assign start_det = scl_q && scl_s && sda_q && !sda_s;
   assign stop_det  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
   import smb_cfg_pkg::*;
#(
   parameter int                NUM_REGS = 9,
   parameter logic [BYTE_W-1:0] ID_CODE  = 8'h01
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 strap_i,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [BYTE_W-1:0]          rd_data,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

   logic strap_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strap_done <= 1'b0;
      else        strap_done <= 1'b1;
   end

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
         localparam logic [BYTE_W-1:0] RST = reg_reset(k);
         localparam logic [BYTE_W-1:0] MSK = reg_wmask(k);
         logic wr_hit;
         assign wr_hit = wr_en && (wr_idx == IDX_W'(k));

         if (k == IDX_ID) begin : g_const
            assign cfg_o[k*BYTE_W +: BYTE_W] = ID_CODE;
         end else if (k == IDX_FS) begin : g_strap
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          q <= RST;
               else if (!strap_done) q[FS_LSB +: 2] <= strap_i;
               else if (wr_hit)     q <= (q & ~MSK) | (wr_data & MSK);
            end
            assign cfg_o[k*BYTE_W +: BYTE_W] = q;
         end else begin : g_plain
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      q <= RST;
               else if (wr_hit) q <= (q & ~MSK) | (wr_data & MSK);
            end
            assign cfg_o[k*BYTE_W +: BYTE_W] = q;
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (rd_idx == IDX_W'(k)) rd_data = cfg_o[k*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
   import smb_cfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h69
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   input  logic [BYTE_W-1:0] cnt_val,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_oe
);

   localparam int              BIT_W   = 4;
   localparam logic [BIT_W-1:0] LAST_RX = BIT_W'(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_TX = BIT_W'(BYTE_W - 1);

   smb_state_e        state;
   smb_phase_e        phase;
   logic [BYTE_W-1:0] sh;
   logic [BIT_W-1:0]  bit_cnt;
   logic [IDX_W-1:0]  ptr;
   logic [BYTE_W-1:0] wr_left;
   logic              byte_mode;
   logic              is_read;
   logic              host_ack;
   logic              rx_ok;

   assign rd_idx = ptr;

   always_comb begin
      rx_ok = 1'b1;
      case (phase)
         PH_ADDR:  rx_ok = (sh[7:1] == DEV_ADDR);
         PH_WDATA: rx_ok = byte_mode || (wr_left != '0);
         default:  rx_ok = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= PH_ADDR;
         sh        <= '0;
         bit_cnt   <= '0;
         ptr       <= '0;
         wr_left   <= '0;
         byte_mode <= 1'b0;
         is_read   <= 1'b0;
         host_ack  <= 1'b0;
         sda_oe    <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state   <= ST_RX;
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_IDLE: ;
               ST_RX: begin
                  if (scl_rise && bit_cnt != LAST_RX) begin
                     sh      <= {sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == LAST_RX) begin
                     if (!rx_ok) begin
                        state <= ST_IDLE;
                     end else begin
                        state  <= ST_ACK;
                        sda_oe <= 1'b1;
                        case (phase)
                           PH_ADDR: is_read <= sh[0];
                           PH_CMD: begin
                              ptr       <= sh[IDX_W-1:0];
                              byte_mode <= sh[BYTE_W-1];
                           end
                           PH_CNT: wr_left <= sh;
                           PH_WDATA: begin
                              wr_en   <= 1'b1;
                              wr_idx  <= ptr;
                              wr_data <= sh;
                              ptr     <= ptr + 1'b1;
                              if (!byte_mode) wr_left <= wr_left - 1'b1;
                           end
                           default: ;
                        endcase
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     if (phase == PH_ADDR && is_read) begin
                        state <= ST_TX;
                        if (byte_mode) begin
                           phase  <= PH_TDATA;
                           sh     <= rd_data;
                           sda_oe <= !rd_data[BYTE_W-1];
                           ptr    <= ptr + 1'b1;
                        end else begin
                           phase  <= PH_TCNT;
                           sh     <= cnt_val;
                           sda_oe <= !cnt_val[BYTE_W-1];
                        end
                     end else begin
                        state <= ST_RX;
                        if (phase == PH_ADDR)                  phase <= PH_CMD;
                        else if (phase == PH_CMD && !byte_mode) phase <= PH_CNT;
                        else                                    phase <= PH_WDATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == LAST_TX) begin
                        sda_oe   <= 1'b0;
                        host_ack <= 1'b0;
                        state    <= ST_HACK;
                     end else begin
                        sh      <= {sh[BYTE_W-2:0], 1'b0};
                        sda_oe  <= !sh[BYTE_W-2];
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_HACK: begin
                  if (scl_s) host_ack <= !sda_s;
                  if (scl_fall) begin
                     if (host_ack) begin
                        state   <= ST_TX;
                        phase   <= PH_TDATA;
                        sh      <= rd_data;
                        sda_oe  <= !rd_data[BYTE_W-1];
                        ptr     <= ptr + 1'b1;
                        bit_cnt <= '0;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
   import smb_cfg_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR    = 7'h69,
   parameter int                NUM_REGS    = 9,
   parameter int                SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] ID_CODE     = 8'h01
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   input  logic [1:0]                 strap_fs_i,
   output logic                       sda_oe_o,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);

   generate
      if (NUM_REGS < IDX_CNT + 1 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs
         $error("NUM_REGS must cover the read-length register and fit the index field");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [BYTE_W-1:0] wr_data;
   logic [IDX_W-1:0]  rd_idx;
   logic [BYTE_W-1:0] rd_data;
   logic [BYTE_W-1:0] cnt_val;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_proto_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .cnt_val   (cnt_val),
      .rd_idx    (rd_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .sda_oe    (sda_oe_o)
   );

   smb_reg_bank #(.NUM_REGS(NUM_REGS), .ID_CODE(ID_CODE)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .strap_i (strap_fs_i),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .cfg_o   (cfg_o)
   );

   assign cnt_val = cfg_o[IDX_CNT*BYTE_W +: BYTE_W];

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
   import smb_cfg_pkg::*;
#(
   parameter int NUM_REGS = 9
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       scl_s,
   input logic                       start_det,
   input logic                       stop_det,
   input logic                       sda_oe,
   input logic                       wr_en,
   input logic [IDX_W-1:0]           wr_idx,
   input logic [BYTE_W-1:0]          wr_data,
   input logic [NUM_REGS*BYTE_W-1:0] cfg
);

   // R12: no SDA change while SCL stays high, except right after START/STOP
   a_r12_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

   // R12: a STOP releases the line
   a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R10: write strobe to an index beyond the bank leaves every register alone
   a_r10_high_index_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_idx) >= NUM_REGS)) |=> $stable(cfg));

   // R13: parallel outputs move only on a write strobe (after the strap load)
   a_r13_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && $past(rst_n)) |=> $stable(cfg));

   // R5: read-length register takes the written byte
   a_r5_count_reg_written: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IDX_CNT)) |=> (cfg[IDX_CNT*BYTE_W +: BYTE_W] == $past(wr_data)));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe_o),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_data   (wr_data),
   .cfg       (cfg_o)
);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 20;   // quarter SCL bit, in clocks
   localparam int NREG       = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            scl_h = 1'b1;
   logic            sda_h = 1'b1;
   logic [1:0]      strap = 2'b10;
   logic            sda_oe;
   logic [NREG*8-1:0] cfg;
   wire             sda_line = sda_h & ~sda_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] obs_byte;
   event       obs_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_cfg_slave u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_h),
      .sda_i      (sda_line),
      .strap_fs_i (strap),
      .sda_oe_o   (sda_oe),
      .cfg_o      (cfg)
   );

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] reg_of(input int k);
      return cfg[k*8 +: 8];
   endfunction

   task automatic bus_start();
      sda_h = 1'b0; wt(Q);
      scl_h = 1'b0; wt(Q);
   endtask

   task automatic bus_rstart();
      sda_h = 1'b1; wt(Q);
      scl_h = 1'b1; wt(Q);
      sda_h = 1'b0; wt(Q);
      scl_h = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wt(Q);
      scl_h = 1'b1; wt(Q);
      sda_h = 1'b1; wt(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_h = b[i]; wt(Q);
         scl_h = 1'b1; wt(2*Q);
         scl_h = 1'b0; wt(Q);
      end
      sda_h = 1'b1; wt(Q);
      scl_h = 1'b1; wt(Q);
      ack = !sda_line;
      wt(Q);
      scl_h = 1'b0; wt(Q);
   endtask

   task automatic tx(input logic [7:0] b, input logic exp_ack, input string tag);
      logic a;
      send_byte(b, a);
      check8(tag, {7'd0, a}, {7'd0, exp_ack});
   endtask

   task automatic rx(input logic [7:0] exp, input logic host_ack, input string tag);
      logic [7:0] b;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      sda_h = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(Q);
         scl_h = 1'b1; wt(Q);
         b[i] = sda_line;
         wt(Q);
         scl_h = 1'b0; wt(Q);
      end
      sda_h = host_ack ? 1'b0 : 1'b1; wt(Q);
      scl_h = 1'b1; wt(2*Q);
      scl_h = 1'b0; wt(Q);
      sda_h = 1'b1;
      obs_byte = b;
      -> obs_ev;
   endtask

   // scoreboard monitor: compares each returned byte against the queue head
   initial begin
      forever begin
         @(obs_ev);
         n_checks++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R4 unexpected byte actual=%02h expected=none", obs_byte);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (obs_byte !== e) begin
               n_fail++;
               $display("FAIL %s read actual=%02h expected=%02h", t, obs_byte, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      wt(5);
      rst_n = 1'b1;
      wt(10);

      // R7 R8 R9 R5: reset contents, strap captured
      check8("R7 reg0", reg_of(0), 8'h07);
      check8("R7 reg1", reg_of(1), 8'hFF);
      check8("R7 reg2", reg_of(2), 8'hFF);
      check8("R7 reg3", reg_of(3), 8'h00);
      check8("R8 reg4 strap", reg_of(4), 8'h08);
      check8("R9 reg5", reg_of(5), 8'h00);
      check8("R7 reg6", reg_of(6), 8'h00);
      check8("R9 reg7", reg_of(7), 8'h01);
      check8("R5 reg8", reg_of(8), 8'h05);
      check8("R12 idle oe", {7'd0, sda_oe}, 8'h00);

      // R2: block write index 0, three bytes
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h00, 1'b1, "R2 cmd");
      tx(8'h03, 1'b1, "R2 cnt");
      tx(8'hA5, 1'b1, "R2 d0");
      tx(8'h3C, 1'b1, "R2 d1");
      tx(8'h5A, 1'b1, "R2 d2");
      bus_stop();
      check8("R2 reg0", reg_of(0), 8'hA5);
      check8("R2 reg1", reg_of(1), 8'h3C);
      check8("R13 reg2", reg_of(2), 8'h5A);

      // R3: byte beyond count refused
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h03, 1'b1, "R2 cmd");
      tx(8'h01, 1'b1, "R2 cnt");
      tx(8'h66, 1'b1, "R2 d0");
      tx(8'h99, 1'b0, "R3 extra nack");
      bus_stop();
      check8("R3 reg3", reg_of(3), 8'h66);
      check8("R3 reg4 untouched", reg_of(4), 8'h08);

      // R1: foreign address
      bus_start();
      tx(8'hA0, 1'b0, "R1 foreign nack");
      tx(8'h00, 1'b0, "R1 ignored after nack");
      bus_stop();
      check8("R1 oe released", {7'd0, sda_oe}, 8'h00);

      // R5: set read length to 3
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h08, 1'b1, "R5 cmd");
      tx(8'h01, 1'b1, "R5 cnt");
      tx(8'h03, 1'b1, "R5 data");
      bus_stop();
      check8("R5 reg8 written", reg_of(8), 8'h03);

      // R4: block read from index 0
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h00, 1'b1, "R4 cmd");
      bus_rstart();
      tx(8'hD3, 1'b1, "R1 read addr");
      rx(8'h03, 1'b1, "R4 count");
      rx(8'hA5, 1'b1, "R4 d0");
      rx(8'h3C, 1'b1, "R4 d1");
      rx(8'h5A, 1'b0, "R4 d2");
      bus_stop();
      check8("R12 oe after read", {7'd0, sda_oe}, 8'h00);

      // R6 R8: byte mode write at index 3
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h83, 1'b1, "R6 cmd");
      tx(8'h77, 1'b1, "R6 d0");
      tx(8'h9E, 1'b1, "R6 d1");
      bus_stop();
      check8("R6 reg3", reg_of(3), 8'h77);
      check8("R8 reg4 overwrite", reg_of(4), 8'h8E);

      // R9: reserved and identification bytes ignore writes
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h85, 1'b1, "R6 cmd");
      tx(8'hFF, 1'b1, "R9 reg5 write");
      tx(8'h33, 1'b1, "R6 reg6 write");
      tx(8'h44, 1'b1, "R9 reg7 write");
      bus_stop();
      check8("R9 reg5 kept", reg_of(5), 8'h00);
      check8("R6 reg6", reg_of(6), 8'h33);
      check8("R9 reg7 kept", reg_of(7), 8'h01);

      // R10: write beyond the bank
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h89, 1'b1, "R10 cmd");
      tx(8'h12, 1'b1, "R10 data acked");
      bus_stop();
      check8("R10 reg8 kept", reg_of(8), 8'h03);
      check8("R10 reg0 kept", reg_of(0), 8'hA5);

      // R6 R10: byte mode read 7, 8, 9 with no count byte
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h87, 1'b1, "R6 cmd");
      bus_rstart();
      tx(8'hD3, 1'b1, "R1 read addr");
      rx(8'h01, 1'b1, "R6 id");
      rx(8'h03, 1'b1, "R6 reg8");
      rx(8'h00, 1'b0, "R10 high index");
      bus_stop();

      // R11: STOP part way through a block write
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h00, 1'b1, "R11 cmd");
      tx(8'h03, 1'b1, "R11 cnt");
      tx(8'h11, 1'b1, "R11 d0");
      tx(8'h22, 1'b1, "R11 d1");
      bus_stop();
      check8("R11 reg0", reg_of(0), 8'h11);
      check8("R11 reg1", reg_of(1), 8'h22);
      check8("R11 reg2 kept", reg_of(2), 8'h5A);

      // R11: START part way through, then a fresh byte-mode read
      bus_start();
      tx(8'hD2, 1'b1, "R1 addr");
      tx(8'h06, 1'b1, "R11 cmd");
      tx(8'h02, 1'b1, "R11 cnt");
      tx(8'h44, 1'b1, "R11 d0");
      bus_rstart();
      tx(8'hD2, 1'b1, "R11 addr after abort");
      tx(8'h86, 1'b1, "R11 cmd");
      bus_rstart();
      tx(8'hD3, 1'b1, "R1 read addr");
      rx(8'h44, 1'b0, "R11 reg6");
      bus_stop();
      check8("R11 reg7 kept", reg_of(7), 8'h01);

      wt(10);
      check8("R4 scoreboard drained", 8'(exp_q.size()), 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule